// File: doc/BRIEF.md
# Power-Gating Sequence Controller

This controller moves a logic domain between running, clock-stopped and power-gated states. When the domain raises its idle request, the controller compares the expected idle length with the cost of waking up from a gated rail. That cost is the switch ramp time plus the restore time, both in clock cycles.

If the idle period pays for the wake cost, the controller runs the full entry sequence. It clamps the domain outputs, has the domain state saved to always-on storage, stops the clock, and then opens the rail switch. For shorter idles it only stops the clock, so no state is lost.

Wake-up is triggered by dropping the idle request. The controller closes the rail switch and waits out the ramp time. It then has the state restored, releases the clamp and restarts the clock. The entry sequence is never cut short. A wake that arrives during it is remembered and acted on as soon as the rail is off.

Top module: `pwr_seq_ctrl`

## Requirements
- R1: After reset, state_o is 0, clk_en is 1, and sleep, iso, save_req and rest_req are 0.
- R2: In the running state (code 0), a high idle_req moves the controller in the next cycle to the save state (code 2) when idle_len > ramp_cycles + rest_cycles. Otherwise it moves to the clock-stopped state (code 1), with clk_en 0 and sleep 0.
- R3: In the clock-stopped state, the controller stays there while idle_req is high. Once idle_req is low, it returns to the running state in the next cycle with clk_en 1.
- R4: In the save state, save_req is 1 and clk_en is 1. The controller stays in this state until save_ack is seen high.
- R5: After save_ack, the controller spends exactly one cycle in the entry state (code 3) with clk_en 0 and sleep 0. It then enters the off state (code 4) with sleep 1. The clock is always stopped before sleep rises.
- R6: iso is 1 in every state from save (code 2) through restore (code 6). It is 0 in the resume state (code 7) and in the running state.
- R7: In the off state, a low idle_req starts the ramp state (code 5) in the next cycle with sleep 0. The ramp state lasts max(R,1) cycles, where R is ramp_cycles sampled on entry to the ramp state. Later changes to ramp_cycles do not alter the count.
- R8: In the restore state (code 6), rest_req is 1 and clk_en is 0 until rest_ack is seen. The controller then spends one cycle in resume (code 7) with clk_en 0. After that it enters the running state with clk_en 1.
- R9: A wake (idle_req low) seen during the save or entry state is remembered. The controller still reaches the off state, spends one cycle there, and then enters the ramp state, even if idle_req has risen again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| idle_req | input | 1 | Domain is idle (high) or wants to run (low) |
| idle_len | input | IW | Expected idle length in cycles |
| ramp_cycles | input | CW | Rail switch ramp time in cycles |
| rest_cycles | input | CW | Restore time in cycles, used for the gating decision |
| save_ack | input | 1 | State save finished |
| rest_ack | input | 1 | State restore finished |
| save_req | output | 1 | Request state save |
| rest_req | output | 1 | Request state restore |
| sleep | output | 1 | Open rail switch (1 = domain unpowered) |
| clk_en | output | 1 | Domain clock enable |
| iso | output | 1 | Clamp domain outputs |
| state_o | output | 3 | Current state code |

## Verification
Assertions check several properties on every cycle. Sleep never rises while the clock is enabled. Save and restore requests are held until acknowledged. The clamp is released only after a restore acknowledge. The short-idle decision always leads to clock stopping alone. A remembered wake always leaves the off state at once.

Other behaviour is visible only in the bench's scenarios. These include the exact cycle length of the ramp and its latching of the ramp setting, and the boundary of the gating decision at equality. They also cover the full order of outputs through a complete sleep and wake, with random lengths and acknowledge delays.

// File: rtl/pgc_pkg.sv
package pgc_pkg;

    typedef enum logic [2:0] {
        PG_RUN    = 3'd0,
        PG_CGATE  = 3'd1,
        PG_SAVE   = 3'd2,
        PG_ENTER  = 3'd3,
        PG_OFF    = 3'd4,
        PG_RAMP   = 3'd5,
        PG_REST   = 3'd6,
        PG_RESUME = 3'd7
    } pg_state_e;

    typedef struct packed {
        logic clk_en;
        logic sleep;
        logic iso;
        logic save_req;
        logic rest_req;
    } pg_ctl_t;

    function automatic pg_ctl_t decode_ctl(pg_state_e s);
        pg_ctl_t c;
        c = '0;
        unique case (s)
            PG_RUN:    c.clk_en = 1'b1;
            PG_CGATE:  c = '0;
            PG_SAVE:   begin c.clk_en = 1'b1; c.iso = 1'b1; c.save_req = 1'b1; end
            PG_ENTER:  c.iso = 1'b1;
            PG_OFF:    begin c.sleep = 1'b1; c.iso = 1'b1; end
            PG_RAMP:   c.iso = 1'b1;
            PG_REST:   begin c.iso = 1'b1; c.rest_req = 1'b1; end
            PG_RESUME: c = '0;
            default:   c = '0;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/pgc_decide.sv
module pgc_decide #(
    parameter int IW = 16,
    parameter int CW = 8
) (
    input  logic [IW-1:0] idle_len,
    input  logic [CW-1:0] ramp_cycles,
    input  logic [CW-1:0] rest_cycles,
    output logic          go_deep
);
    localparam int SW = (IW > CW + 1) ? IW : CW + 1;

    logic [SW-1:0] wake_cost;
    logic [SW-1:0] idle_ext;

    always_comb begin
        wake_cost = SW'(ramp_cycles) + SW'(rest_cycles);
        idle_ext  = SW'(idle_len);
        go_deep   = idle_ext > wake_cost;
    end
endmodule

// File: rtl/pgc_timer.sv
module pgc_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic          tick,
    output logic          last
);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (tick && cnt > CW'(1))
            cnt <= cnt - CW'(1);
    end

    assign last = (cnt <= CW'(1));
endmodule

// File: rtl/pgc_outdec.sv
module pgc_outdec
    import pgc_pkg::*;
(
    input  pg_state_e state,
    output pg_ctl_t   ctl
);
    always_comb ctl = decode_ctl(state);
endmodule

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl
    import pgc_pkg::*;
#(
    parameter int IW = 16,
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          idle_req,
    input  logic [IW-1:0] idle_len,
    input  logic [CW-1:0] ramp_cycles,
    input  logic [CW-1:0] rest_cycles,
    input  logic          save_ack,
    input  logic          rest_ack,
    output logic          save_req,
    output logic          rest_req,
    output logic          sleep,
    output logic          clk_en,
    output logic          iso,
    output logic [2:0]    state_o
);
    pg_state_e state, nxt;
    pg_ctl_t   ctl;
    logic      go_deep;
    logic      ramp_last;
    logic      wake_pend;
    logic      ramp_load;

    pgc_decide #(.IW(IW), .CW(CW)) u_dec (
        .idle_len    (idle_len),
        .ramp_cycles (ramp_cycles),
        .rest_cycles (rest_cycles),
        .go_deep     (go_deep)
    );

    assign ramp_load = (state == PG_OFF) && (nxt == PG_RAMP);

    pgc_timer #(.CW(CW)) u_tmr (
        .clk      (clk),
        .rst      (rst),
        .load     (ramp_load),
        .load_val (ramp_cycles),
        .tick     (state == PG_RAMP),
        .last     (ramp_last)
    );

    pgc_outdec u_out (
        .state (state),
        .ctl   (ctl)
    );

    always_comb begin
        nxt = state;
        unique case (state)
            PG_RUN:    if (idle_req) nxt = go_deep ? PG_SAVE : PG_CGATE;
            PG_CGATE:  if (!idle_req) nxt = PG_RUN;
            PG_SAVE:   if (save_ack) nxt = PG_ENTER;
            PG_ENTER:  nxt = PG_OFF;
            PG_OFF:    if (wake_pend || !idle_req) nxt = PG_RAMP;
            PG_RAMP:   if (ramp_last) nxt = PG_REST;
            PG_REST:   if (rest_ack) nxt = PG_RESUME;
            PG_RESUME: nxt = PG_RUN;
            default:   nxt = PG_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= PG_RUN;
            wake_pend <= 1'b0;
        end else begin
            state <= nxt;
            if ((state == PG_SAVE || state == PG_ENTER) && !idle_req)
                wake_pend <= 1'b1;
            else if (state == PG_OFF)
                wake_pend <= 1'b0;
        end
    end

    assign save_req = ctl.save_req;
    assign rest_req = ctl.rest_req;
    assign sleep    = ctl.sleep;
    assign clk_en   = ctl.clk_en;
    assign iso      = ctl.iso;
    assign state_o  = state;

    // R2: short idle leads to clock stop only
    a_r2_short_idle_cgate: assert property (@(posedge clk) disable iff (rst)
        (state == PG_RUN && idle_req && !go_deep) |=> (state == PG_CGATE && !sleep));

    // R4: save request held until acknowledged
    a_r4_save_hold: assert property (@(posedge clk) disable iff (rst)
        (save_req && !save_ack) |=> save_req);

    // R5: clock stopped and outputs clamped before the rail opens
    a_r5_clk_before_sleep: assert property (@(posedge clk) disable iff (rst)
        $rose(sleep) |-> ($past(!clk_en) && $past(iso)));

    a_r5_no_clock_while_off: assert property (@(posedge clk) disable iff (rst)
        sleep |-> (!clk_en && iso));

    // R6: clamp released only after restore acknowledge
    a_r6_iso_release: assert property (@(posedge clk) disable iff (rst)
        $fell(iso) |-> $past(rest_ack));

    // R8: restore request held until acknowledged
    a_r8_rest_hold: assert property (@(posedge clk) disable iff (rst)
        (rest_req && !rest_ack) |=> rest_req);

    // R9: remembered wake leaves the off state at once
    a_r9_pending_wake: assert property (@(posedge clk) disable iff (rst)
        (state == PG_OFF && wake_pend) |=> (state == PG_RAMP));
endmodule

// File: tb/sim_pwr_seq_ctrl.sv
module sim_pwr_seq_ctrl;
    localparam int IW = 16;
    localparam int CW = 8;

    logic          clk = 1'b0;
    logic          rst;
    logic          idle_req;
    logic [IW-1:0] idle_len;
    logic [CW-1:0] ramp_cycles;
    logic [CW-1:0] rest_cycles;
    logic          save_ack;
    logic          rest_ack;
    logic          save_req, rest_req, sleep, clk_en, iso;
    logic [2:0]    state_o;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;

    always #10 clk = ~clk;

    pwr_seq_ctrl #(.IW(IW), .CW(CW)) u0 (
        .clk(clk), .rst(rst), .idle_req(idle_req), .idle_len(idle_len),
        .ramp_cycles(ramp_cycles), .rest_cycles(rest_cycles),
        .save_ack(save_ack), .rest_ack(rest_ack),
        .save_req(save_req), .rest_req(rest_req), .sleep(sleep),
        .clk_en(clk_en), .iso(iso), .state_o(state_o)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=%0d cycles expected=<150000", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic bit exp_deep(int len, int r, int s);
        return len > (r + s);
    endfunction

    function automatic int exp_ramp_len(int r);
        return (r < 1) ? 1 : r;
    endfunction

    // early: 0 none, 1 wake during save, 2 wake pulse in entry state
    task automatic scenario(input int len, input int r, input int s,
                            input int sd, input int rd, input int early);
        idle_len = IW'(len); ramp_cycles = CW'(r); rest_cycles = CW'(s);
        idle_req = 1'b1;
        step();
        if (!exp_deep(len, r, s)) begin
            chk("R2 cgate state", state_o, 1);
            chk("R2 cgate clk_en", clk_en, 0);
            chk("R2 cgate sleep", sleep, 0);
            for (int k = 0; k < sd + 1; k++) begin
                step();
                chk("R3 cgate hold", state_o, 1);
            end
            idle_req = 1'b0;
            step();
            chk("R3 back to run", state_o, 0);
            chk("R3 clk_en", clk_en, 1);
            return;
        end
        chk("R2 save state", state_o, 2);
        chk("R6 iso in save", iso, 1);
        chk("R4 save_req", save_req, 1);
        chk("R4 clk_en in save", clk_en, 1);
        if (early == 1) idle_req = 1'b0;
        for (int k = 0; k < sd; k++) begin
            step();
            chk("R4 wait ack", state_o, 2);
            chk("R4 req held", save_req, 1);
        end
        save_ack = 1'b1;
        step();
        save_ack = 1'b0;
        chk("R5 entry state", state_o, 3);
        chk("R5 clk off", clk_en, 0);
        chk("R5 sleep low", sleep, 0);
        if (early == 2) idle_req = 1'b0;
        step();
        chk("R5 off state", state_o, 4);
        chk("R5 sleep", sleep, 1);
        chk("R6 iso off", iso, 1);
        if (early == 2) idle_req = 1'b1;
        if (early == 0) begin
            for (int k = 0; k < sd + 1; k++) begin
                step();
                chk("R7 stays off", state_o, 4);
            end
            idle_req = 1'b0;
        end
        step();
        chk(early != 0 ? "R9 pending wake" : "R7 ramp state", state_o, 5);
        chk("R7 sleep released", sleep, 0);
        idle_req = 1'b0;
        ramp_cycles = CW'($urandom_range(0, 40));
        for (int k = 1; k < exp_ramp_len(r); k++) begin
            step();
            chk("R7 ramp length", state_o, 5);
        end
        step();
        chk("R7 ramp end", state_o, 6);
        chk("R8 rest_req", rest_req, 1);
        chk("R8 clk off in restore", clk_en, 0);
        chk("R6 iso in restore", iso, 1);
        for (int k = 0; k < rd; k++) begin
            step();
            chk("R8 wait ack", state_o, 6);
        end
        rest_ack = 1'b1;
        step();
        rest_ack = 1'b0;
        chk("R8 resume", state_o, 7);
        chk("R6 iso released", iso, 0);
        chk("R8 clk still off", clk_en, 0);
        step();
        chk("R8 run", state_o, 0);
        chk("R8 clk on", clk_en, 1);
    endtask

    initial begin
        void'($urandom(32'd4242));
        rst = 1'b1; idle_req = 1'b0; idle_len = '0;
        ramp_cycles = CW'(20); rest_cycles = CW'(20);
        save_ack = 1'b0; rest_ack = 1'b0;
        step(); step();
        rst = 1'b0;
        chk("R1 state", state_o, 0);
        chk("R1 clk_en", clk_en, 1);
        chk("R1 sleep", sleep, 0);
        chk("R1 iso", iso, 0);
        chk("R1 reqs", save_req | rest_req, 0);

        scenario(40, 20, 20, 1, 1, 0);
        scenario(41, 20, 20, 2, 3, 0);
        scenario(5, 0, 3, 0, 0, 0);
        scenario(10, 0, 3, 0, 0, 0);
        scenario(30, 1, 4, 3, 0, 1);
        scenario(30, 6, 4, 0, 2, 2);

        for (int i = 0; i < 200; i++) begin
            scenario($urandom_range(0, 80), $urandom_range(0, 30),
                     $urandom_range(0, 30), $urandom_range(0, 3),
                     $urandom_range(0, 3), $urandom_range(0, 2));
            step();
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule